// File: doc/BRIEF.md
# Single-Cycle Integer Core with Sticky Halt

This block is a small 32-bit processor that completes one instruction per clock. In each cycle it presents the program counter to an instruction read port and decodes the returned word. It reads two operands from a 32-entry register file and runs the arithmetic unit. A load or store goes through a data port, the result is written back, and the program counter advances. Both ports address one unified 64 KiB word-organised memory, which sits outside the block. The read ports are combinational: the word for the current address must be valid in the same cycle.

The core has no exception path. An illegal condition latches a halt flag instead. The conditions are an opcode or function code it does not support, a misaligned load or store, or a fetch outside the memory. While the flag is set, the program counter, the registers and memory stay frozen until the next reset. A system uses the `halted` output to tell that a program has finished or has failed.

Top module: `scpu_top`

## Requirements
- R1: After a synchronous active-low reset the fetch address is byte 0x4000 (word index 0x1000), `halted` is 0, register 29 holds 0xFFFC, register 28 holds 0xC000, and all other registers hold 0.
- R2: Instruction fields are opcode [31:26], first source [25:21], second source/target [20:16], destination [15:11], function [5:0], immediate [15:0] and jump target [25:0]. With opcode 0 the function code selects the operation: 32 add, 34 subtract, 36 and, 37 or, 39 nor, 42 signed less-than and 43 unsigned less-than. The result is written to the destination field register.
- R3: The immediate forms write to the [20:16] register. They are opcode 8 (add the sign-extended immediate), 10 (signed less-than against the sign-extended immediate), 11 (unsigned less-than against the sign-extended immediate) and 15 (immediate shifted left by 16).
- R4: Opcode 35 loads and opcode 43 stores. Both use the byte address first-source + sign-extended immediate, and the memory word index is address bits [15:2]. A load writes the read word to the [20:16] register. A store raises `dmem_we` for that one cycle, with `dmem_wdata` equal to the [20:16] register.
- R5: Opcode 4 compares both source registers. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise, and for every other non-jump instruction, the next PC is PC+4.
- R6: Opcode 2 sets PC to PC+4 bits [31:28], followed by the 26-bit target and two zero bits.
- R7: Register 0 always reads as zero. Writes to it are discarded.
- R8: Any other opcode, or any other function code under opcode 0, sets `halted` on the next clock. The PC does not advance and no store is issued.
- R9: A load or store whose byte address has bits [1:0] not equal to zero sets `halted` and issues no store.
- R10: A fetch from a PC with bits [1:0] not equal to zero, or from a PC at or above 0x10000, sets `halted`.
- R11: Once set, `halted` stays high and PC holds still with `dmem_we` low on every cycle until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 14 | Word index of the instruction being fetched (PC bits [15:2]) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 14 | Word index of the load/store address |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |
| dmem_we | output | 1 | Store strobe, one cycle per committed store |
| dmem_wdata | output | 32 | Store data |
| halted | output | 1 | Sticky halt flag |

## Verification
A behavioural instruction-level model in the bench runs alongside the core. It is compared every cycle on the fetch address, the halt flag and the store port. Register contents become visible through stores.

A long mixed program covers several patterns. Operands with opposite signs separate signed from unsigned compares and logical from arithmetic results. A countdown loop exercises backward jumps and forward taken branches, and a non-taken branch is included. Writes to register 0 are checked, and the reset values of the pointer registers are stored out.

Separate short programs each end in one halt cause: a bad function code, a misaligned load, a misaligned store, and a jump that lands just beyond the memory. Each one shows that the halt is sticky and that it clears on reset.

// File: rtl/scpu_pkg.sv
// Shared encodings and control bundle for the single-cycle core.
// Assumes a 32-bit instruction word with a 6-bit opcode and 6-bit function code.
package scpu_pkg;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SLT,
        ALU_SLTU,
        ALU_LUI
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;   // instruction writes a register
        logic    dst_rd;   // destination is [15:11] rather than [20:16]
        logic    use_imm;  // second ALU operand is the extended immediate
        alu_op_e alu_op;
        logic    mem_rd;
        logic    mem_wr;
        logic    branch;
        logic    jump;
        logic    illegal;
    } ctrl_t;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_JMP   = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_SLTI  = 6'd10;
    localparam logic [5:0] OPC_SLTIU = 6'd11;
    localparam logic [5:0] OPC_LUI   = 6'd15;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;
    localparam logic [5:0] FN_SLTU = 6'd43;

endpackage

// File: rtl/scpu_decode.sv
// Opcode/function decoder: turns the two code fields into a control bundle.
// Assumes nothing about operands; unknown codes raise the illegal flag.
module scpu_decode
    import scpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);

    // Purpose: map opcode and function code to control signals.
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        unique case (opcode)
            OPC_REG: begin
                ctl.reg_we = 1'b1;
                ctl.dst_rd = 1'b1;
                unique case (funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_NOR:  ctl.alu_op = ALU_NOR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    FN_SLTU: ctl.alu_op = ALU_SLTU;
                    default: begin
                        ctl.reg_we  = 1'b0;
                        ctl.illegal = 1'b1;
                    end
                endcase
            end
            OPC_ADDI:  begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.alu_op = ALU_ADD;  end
            OPC_SLTI:  begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.alu_op = ALU_SLT;  end
            OPC_SLTIU: begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.alu_op = ALU_SLTU; end
            OPC_LUI:   begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.alu_op = ALU_LUI;  end
            OPC_LOAD:  begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.mem_rd = 1'b1; end
            OPC_STORE: begin ctl.use_imm = 1'b1; ctl.mem_wr = 1'b1; end
            OPC_BEQ:   begin ctl.branch = 1'b1; ctl.alu_op = ALU_SUB; end
            OPC_JMP:   begin ctl.jump = 1'b1; end
            default:   begin ctl.illegal = 1'b1; end
        endcase
    end

endmodule

// File: rtl/scpu_alu.sv
// Integer ALU: add, subtract, bitwise ops, signed/unsigned less-than, upper-immediate.
// Assumes both operands are already selected and extended by the caller.
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         zero
);

    localparam int HALF = W / 2;

    // Purpose: compute the selected operation.
    always_comb begin
        unique case (op)
            ALU_ADD:  res = a + b;
            ALU_SUB:  res = a - b;
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            ALU_NOR:  res = ~(a | b);
            ALU_SLT:  res = W'($signed(a) < $signed(b));
            ALU_SLTU: res = W'(a < b);
            ALU_LUI:  res = b << HALF;
            default:  res = '0;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/scpu_regs.sv
// Register file with two combinational read ports and one write port.
// Entry 0 has no storage and reads as zero; two entries reset to given pointers.
module scpu_regs #(
    parameter int          NUM     = 32,
    parameter int          W       = 32,
    parameter int          SP_IDX  = 29,
    parameter logic [31:0] SP_INIT = 32'h0000_FFFC,
    parameter int          GP_IDX  = 28,
    parameter logic [31:0] GP_INIT = 32'h0000_C000,
    localparam int         AW      = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] regs [1:NUM-1];

    for (genvar i = 1; i < NUM; i++) begin : g_reg
        localparam logic [W-1:0] INIT = (i == SP_IDX) ? W'(SP_INIT) :
                                        (i == GP_IDX) ? W'(GP_INIT) : '0;
        // Purpose: hold one register, load reset value or write data.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= INIT;
            else if (wr_en && wr_addr == AW'(i))
                regs[i] <= wr_data;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/scpu_top.sv
// Single-cycle core: fetch, decode, register read, execute, memory, write-back and
// PC update all happen within one clock. Memory is external with same-cycle reads.
// Illegal conditions latch a sticky halt that freezes PC, registers and stores.
module scpu_top
    import scpu_pkg::*;
#(
    parameter int          MEM_BYTES = 65536,
    parameter logic [31:0] RESET_PC  = 32'h0000_4000,
    parameter logic [31:0] SP_INIT   = 32'h0000_FFFC,
    parameter logic [31:0] GP_INIT   = 32'h0000_C000,
    localparam int         ADDR_W    = $clog2(MEM_BYTES),
    localparam int         WORD_AW   = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [WORD_AW-1:0] imem_addr,
    input  logic [31:0]        imem_rdata,
    output logic [WORD_AW-1:0] dmem_addr,
    input  logic [31:0]        dmem_rdata,
    output logic               dmem_we,
    output logic [31:0]        dmem_wdata,
    output logic               halted
);

    localparam int NREGS = 32;
    localparam int RAW   = $clog2(NREGS);

    logic [31:0] pc, pc_plus4, pc_next, imm_sx, alu_b, alu_res, rs_val, rt_val, wb_data;
    logic        alu_zero, fetch_bad, mem_bad, stop, commit;
    logic [RAW-1:0] f_rs, f_rt, f_rd, wb_addr;
    logic [4:0]  unused_shamt;
    ctrl_t       ctl;

    // field split
    assign f_rs         = imem_rdata[25:21];
    assign f_rt         = imem_rdata[20:16];
    assign f_rd         = imem_rdata[15:11];
    assign unused_shamt = imem_rdata[10:6];
    assign imm_sx       = {{16{imem_rdata[15]}}, imem_rdata[15:0]};

    scpu_decode u_dec (
        .opcode (imem_rdata[31:26]),
        .funct  (imem_rdata[5:0]),
        .ctl    (ctl)
    );

    scpu_regs #(
        .NUM     (NREGS),
        .W       (32),
        .SP_IDX  (29),
        .SP_INIT (SP_INIT),
        .GP_IDX  (28),
        .GP_INIT (GP_INIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_a    (f_rs),
        .ra_b    (f_rt),
        .rd_a    (rs_val),
        .rd_b    (rt_val),
        .wr_en   (commit && ctl.reg_we),
        .wr_addr (wb_addr),
        .wr_data (wb_data)
    );

    assign alu_b = ctl.use_imm ? imm_sx : rt_val;

    scpu_alu #(.W(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctl.alu_op),
        .res  (alu_res),
        .zero (alu_zero)
    );

    // halt causes
    assign fetch_bad = (pc[1:0] != 2'b00) || (pc >= 32'(MEM_BYTES));
    assign mem_bad   = (ctl.mem_rd || ctl.mem_wr) && (alu_res[1:0] != 2'b00);
    assign stop      = fetch_bad || ctl.illegal || mem_bad;
    assign commit    = rst_n && !halted && !stop;

    // memory and write-back
    assign imem_addr  = pc[ADDR_W-1:2];
    assign dmem_addr  = alu_res[ADDR_W-1:2];
    assign dmem_wdata = rt_val;
    assign dmem_we    = commit && ctl.mem_wr;
    assign wb_data    = ctl.mem_rd ? dmem_rdata : alu_res;
    assign wb_addr    = ctl.dst_rd ? f_rd : f_rt;

    // next PC
    assign pc_plus4 = pc + 32'd4;

    // Purpose: choose among sequential, branch and jump successors.
    always_comb begin
        if (ctl.jump)
            pc_next = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};
        else if (ctl.branch && alu_zero)
            pc_next = pc_plus4 + {imm_sx[29:0], 2'b00};
        else
            pc_next = pc_plus4;
    end

    // Purpose: advance PC or latch the sticky halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= RESET_PC;
            halted <= 1'b0;
        end else if (!halted) begin
            if (stop)
                halted <= 1'b1;
            else
                pc <= pc_next;
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R11
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc)); // R11
    AST_HALT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && stop) |=> (halted && $stable(pc))); // R8
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !ctl.jump && !ctl.branch) |=> (pc == $past(pc) + 32'd4)); // R5
    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ctl.jump) |=> (pc[31:28] == $past(pc_plus4[31:28]) && pc[1:0] == 2'b00)); // R6

endmodule

// File: tb/sim_scpu_top.sv
`timescale 1ns/1ps
module sim_scpu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] imem_addr, dmem_addr;
    logic [31:0] imem_rdata, dmem_rdata, dmem_wdata;
    logic        dmem_we, halted;

    int total = 0;
    int bad   = 0;
    int mem_ver = 0;

    logic [31:0] dut_mem [int];
    logic [31:0] ref_mem [int];
    logic [31:0] prog [$];

    logic [31:0] mregs [32];
    logic [31:0] mpc;
    bit          mhalt;

    always #4 clk = ~clk;

    scpu_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .halted     (halted)
    );

    function automatic logic [31:0] dut_rd(logic [13:0] idx, int ver);
        int k;
        k = int'(idx) + ver * 0;
        return dut_mem.exists(k) ? dut_mem[k] : 32'h0;
    endfunction

    function automatic logic [31:0] ref_rd(int idx);
        return ref_mem.exists(idx) ? ref_mem[idx] : 32'h0;
    endfunction

    assign imem_rdata = dut_rd(imem_addr, mem_ver);
    assign dmem_rdata = dut_rd(dmem_addr, mem_ver);

    always @(posedge clk) begin
        if (dmem_we) begin
            dut_mem[int'(dmem_addr)] = dmem_wdata;
            mem_ver = mem_ver + 1;
        end
    end

    // encoders
    function automatic logic [31:0] rt_op(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] it_op(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] j_op(int tgt);
        return {6'd2, 26'(tgt)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: executes one instruction from the model state.
    task automatic model_step(output string tag, output bit we,
                              output logic [13:0] wa, output logic [31:0] wd);
        logic [31:0] ins, a, b, sx, addr, val;
        int op, fn, rs, rt, rd, dst;
        bit wr;
        we = 0; wa = '0; wd = '0; wr = 0; dst = 0; val = '0;
        if (mhalt) begin tag = "R11"; return; end
        if (mpc[1:0] != 0 || mpc >= 32'h10000) begin mhalt = 1; tag = "R10"; return; end
        ins = ref_rd(int'(mpc >> 2));
        op = int'(ins[31:26]); fn = int'(ins[5:0]);
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = mregs[rs]; b = mregs[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        tag = "R3";
        case (op)
            0: begin
                tag = "R2"; wr = 1; dst = rd;
                case (fn)
                    32: val = a + b;
                    34: val = a - b;
                    36: val = a & b;
                    37: val = a | b;
                    39: val = ~(a | b);
                    42: val = ($signed(a) < $signed(b)) ? 1 : 0;
                    43: val = (a < b) ? 1 : 0;
                    default: begin mhalt = 1; tag = "R8"; return; end
                endcase
            end
            8:  begin wr = 1; dst = rt; val = a + sx; end
            10: begin wr = 1; dst = rt; val = ($signed(a) < $signed(sx)) ? 1 : 0; end
            11: begin wr = 1; dst = rt; val = (a < sx) ? 1 : 0; end
            15: begin wr = 1; dst = rt; val = {ins[15:0], 16'h0}; end
            35, 43: begin
                tag = "R4";
                addr = a + sx;
                if (addr[1:0] != 0) begin mhalt = 1; tag = "R9"; return; end
                if (op == 35) begin
                    wr = 1; dst = rt; val = ref_rd(int'(addr[15:2]));
                end else begin
                    we = 1; wa = addr[15:2]; wd = b;
                    ref_mem[int'(addr[15:2])] = b;
                    if (rt == 0) tag = "R7";
                end
            end
            4: begin
                tag = "R5";
                if (a == b) begin mpc = mpc + 4 + (sx << 2); return; end
            end
            2: begin
                tag = "R6";
                mpc = {mpc[31:28] + ((mpc[27:0] + 28'd4) == 0 ? 4'd1 : 4'd0), ins[25:0], 2'b00};
                return;
            end
            default: begin mhalt = 1; tag = "R8"; return; end
        endcase
        if (wr && dst != 0) mregs[dst] = val;
        if (wr && dst == 0) tag = "R7";
        mpc = mpc + 4;
    endtask

    task automatic run_prog(int run_idx);
        string tag;
        bit eb;
        logic [13:0] ea;
        logic [31:0] ed;
        int after;
        @(negedge clk);
        rst_n = 1'b0;
        dut_mem.delete();
        ref_mem.delete();
        foreach (prog[i]) begin
            dut_mem[32'h1000 + i] = prog[i];
            ref_mem[32'h1000 + i] = prog[i];
        end
        mem_ver = mem_ver + 1;
        repeat (2) @(negedge clk);
        foreach (mregs[i]) mregs[i] = '0;
        mregs[29] = 32'h0000_FFFC;
        mregs[28] = 32'h0000_C000;
        mpc = 32'h4000;
        mhalt = 0;
        rst_n = 1'b1;
        #1;
        chk("R1 reset fetch", 32'(imem_addr), 32'h1000);
        chk("R1 reset halt", 32'(halted), 32'h0);
        if (run_idx > 0) chk("R11 reset clears halt", 32'(halted), 32'h0);
        after = 0;
        for (int cyc = 0; cyc < 400 && after < 4; cyc++) begin
            if (cyc > 0) #1;
            chk("fetch address", 32'(imem_addr), 32'(mpc[15:2]));
            chk("halt flag", 32'(halted), 32'(mhalt));
            if (mhalt) after++;
            model_step(tag, eb, ea, ed);
            chk(tag, 32'(dmem_we), 32'(eb));
            if (eb) begin
                chk(tag, 32'(dmem_addr), 32'(ea));
                chk(tag, dmem_wdata, ed);
            end
            @(negedge clk);
        end
        chk("R11 halted at end", 32'(halted), 32'h1);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Program 1: mixed arithmetic, memory, branches, jump, ends on bad opcode (R8)
        prog.delete();
        prog.push_back(it_op(8, 0, 1, 100));          // r1 = 100
        prog.push_back(it_op(8, 0, 2, -7));           // r2 = -7
        prog.push_back(rt_op(1, 2, 3, 32));           // R2 add
        prog.push_back(rt_op(2, 1, 4, 34));           // R2 sub
        prog.push_back(rt_op(1, 2, 5, 36));           // and
        prog.push_back(rt_op(1, 2, 6, 37));           // or
        prog.push_back(rt_op(1, 2, 7, 39));           // nor
        prog.push_back(rt_op(2, 1, 8, 42));           // signed lt -> 1
        prog.push_back(rt_op(2, 1, 9, 43));           // unsigned lt -> 0
        prog.push_back(it_op(10, 2, 10, -1));         // R3 slti
        prog.push_back(it_op(11, 1, 11, -1));         // R3 sltiu
        prog.push_back(it_op(15, 0, 12, 16'h1234));   // R3 lui
        prog.push_back(it_op(8, 0, 0, 5));            // R7 write r0
        prog.push_back(it_op(43, 0, 0, 12));          // R7 store r0
        prog.push_back(it_op(43, 0, 29, 0));          // R1 sp
        prog.push_back(it_op(43, 0, 28, 4));          // R1 gp
        for (int r = 3; r <= 12; r++)
            prog.push_back(it_op(43, 0, r, 32'h100 + 4 * r));
        prog.push_back(it_op(35, 0, 13, 32'h10C));    // R4 load r3's copy
        prog.push_back(it_op(43, 0, 13, 32'h200));
        prog.push_back(it_op(4, 1, 1, 1));            // R5 taken
        prog.push_back(it_op(8, 0, 14, 1));           // skipped
        prog.push_back(it_op(43, 0, 14, 32'h204));
        prog.push_back(it_op(4, 1, 2, 1));            // R5 not taken
        prog.push_back(it_op(8, 0, 15, 2));
        prog.push_back(it_op(43, 0, 15, 32'h208));
        prog.push_back(it_op(8, 0, 17, 3));           // loop counter
        prog.push_back(it_op(8, 17, 17, -1));         // loop body
        prog.push_back(it_op(4, 17, 0, 1));           // exit when zero
        prog.push_back(j_op(32'h1000 + prog.size() - 2)); // R6 backward jump
        prog.push_back(it_op(43, 0, 17, 32'h20C));
        prog.push_back(32'hFC00_0000);                // R8 unsupported opcode
        run_prog(0);

        // Program 2: unsupported function code (R8)
        prog.delete();
        prog.push_back(it_op(8, 0, 1, 1));
        prog.push_back(rt_op(1, 1, 2, 48));
        prog.push_back(it_op(43, 0, 1, 0));
        run_prog(1);

        // Program 3: misaligned load (R9)
        prog.delete();
        prog.push_back(it_op(8, 0, 1, 2));
        prog.push_back(it_op(35, 1, 2, 0));
        prog.push_back(it_op(43, 0, 1, 0));
        run_prog(2);

        // Program 4: misaligned store, must not write (R9)
        prog.delete();
        prog.push_back(it_op(8, 0, 1, 1));
        prog.push_back(it_op(43, 0, 1, 3));
        run_prog(3);

        // Program 5: jump to 0x10000, fetch out of range (R10)
        prog.delete();
        prog.push_back(j_op(32'h4000));
        run_prog(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule